// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Unit

This block supplies the two source operands of the instruction that sits in the decode stage of a five-stage in-order pipeline. The register file is read before older instructions have written their results back. To correct this, the block compares each decode source register ID with the destination IDs that are still pending further down the pipe. It then substitutes the newest pending result for the stale register-file value.

The block also works out the ALU-result destination register of the decoded instruction, so that later stages can in turn forward against it. The logic is purely combinational. The register file, the ALU and the data memory drive its inputs and are outside the block.

Top module: `opfwd_unit`

## Requirements
- R1: When the decode opcode is 7 (conditional/unconditional jump) or 8 (call), `val_a_o` equals `d_valp_i`, whatever the pending destinations hold.
- R2: A source ID that matches `e_dst_e_i` takes `e_val_e_i`, ahead of every other pending source.
- R3: Without an execute match, a match on `m_dst_m_i` takes `m_val_m_i`, ahead of the memory-stage ALU result and both write-back values.
- R4: Without the two above, a match on `m_dst_e_i` takes `m_val_e_i`, ahead of both write-back values.
- R5: Without the three above, a match on `w_dst_m_i` takes `w_val_m_i` rather than `w_val_e_i`.
- R6: A register being written back through `w_dst_e_i` and read in the same cycle delivers `w_val_e_i`, not the register-file value.
- R7: With no pending destination equal to the source ID, the operand equals the register-file read value (`rf_val_a_i` / `rf_val_b_i`).
- R8: ID 0xF means "no register". A source of 0xF never matches, even when pending destinations are also 0xF, so the register-file value passes through.
- R9: `val_b_o` follows the same five-level order as `val_a_o` and has no valP case: for a call or jump it still forwards.
- R10: `dst_e_o` is `d_rb_i` for opcodes 2 (register move), 3 (immediate move) and 6 (ALU op). It is 4, the stack pointer, for opcodes 8, 9, 10 and 11 (call, return, push, pop). It is 0xF for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode_i | input | 4 | Opcode of the decode-stage instruction |
| d_rb_i | input | 4 | rB field of the decode-stage instruction |
| d_src_a_i | input | 4 | Source A register ID |
| d_src_b_i | input | 4 | Source B register ID |
| d_valp_i | input | 64 | Address of the following instruction |
| rf_val_a_i | input | 64 | Register-file read for source A |
| rf_val_b_i | input | 64 | Register-file read for source B |
| e_dst_e_i | input | 4 | Execute-stage ALU destination |
| e_val_e_i | input | 64 | Execute-stage ALU result |
| m_dst_m_i | input | 4 | Memory-stage load destination |
| m_val_m_i | input | 64 | Memory-stage load data |
| m_dst_e_i | input | 4 | Memory-stage ALU destination |
| m_val_e_i | input | 64 | Memory-stage ALU result |
| w_dst_m_i | input | 4 | Write-back load destination |
| w_val_m_i | input | 64 | Write-back load data |
| w_dst_e_i | input | 4 | Write-back ALU destination |
| w_val_e_i | input | 64 | Write-back ALU result |
| val_a_o | output | 64 | Forwarded operand A |
| val_b_o | output | 64 | Forwarded operand B |
| dst_e_o | output | 4 | ALU destination of the decoded instruction |

## Verification
The block holds no state, so a fault shows at the ports in the same evaluation as the stimulus. A wrong priority rank shows as an operand that equals an older pending value when two or more stages target the same register. This is why every pair of colliding stages is driven with distinct data words. An RNONE comparison that is not masked shows as a forwarded value where the register-file word was expected. A broken valP path shows only for the call and jump opcodes.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int RID_W = 4;
  localparam int XLEN  = 64;
  localparam int NSRC  = 5;
  localparam logic [RID_W-1:0] RID_NONE = '1;
  localparam logic [RID_W-1:0] RID_SP   = 4'd4;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JMP   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;
endpackage

// File: rtl/opfwd_dst_sel.sv
module opfwd_dst_sel
  import opfwd_pkg::*;
#(
  parameter int RW = RID_W
) (
  input  logic [3:0]    icode_i,
  input  logic [RW-1:0] rb_i,
  output logic [RW-1:0] dst_e_o
);
  localparam logic [RW-1:0] NONE = '1;

  always_comb begin
    unique case (icode_i)
      OP_RRMOV, OP_IRMOV, OP_ALU:        dst_e_o = rb_i;
      OP_CALL, OP_RET, OP_PUSH, OP_POP:  dst_e_o = RW'(RID_SP);
      default:                           dst_e_o = NONE;
    endcase
  end
endmodule

// File: rtl/opfwd_operand_mux.sv
module opfwd_operand_mux
  import opfwd_pkg::*;
#(
  parameter int  W        = XLEN,
  parameter int  RW       = RID_W,
  parameter int  N        = NSRC,
  parameter bit  USE_VALP = 1'b1
) (
  input  logic          take_valp_i,
  input  logic [W-1:0]  valp_i,
  input  logic [RW-1:0] src_id_i,
  input  logic [W-1:0]  rf_val_i,
  input  logic [RW-1:0] pend_id_i  [N],
  input  logic [W-1:0]  pend_val_i [N],
  output logic [W-1:0]  val_o
);
  localparam logic [RW-1:0] NONE = '1;

  logic [W-1:0] fwd_val;

  // index 0 is newest; scan oldest first so newer entries override
  always_comb begin
    fwd_val = rf_val_i;
    for (int k = N - 1; k >= 0; k--) begin
      if (src_id_i != NONE && pend_id_i[k] == src_id_i) fwd_val = pend_val_i[k];
    end
  end

  generate
    if (USE_VALP) begin : g_valp
      assign val_o = take_valp_i ? valp_i : fwd_val;
    end else begin : g_plain
      logic unused_valp;
      assign unused_valp = ^{take_valp_i, valp_i};
      assign val_o = fwd_val;
    end
  endgenerate
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
(
  input  logic [3:0]       d_icode_i,
  input  logic [RID_W-1:0] d_rb_i,
  input  logic [RID_W-1:0] d_src_a_i,
  input  logic [RID_W-1:0] d_src_b_i,
  input  logic [XLEN-1:0]  d_valp_i,
  input  logic [XLEN-1:0]  rf_val_a_i,
  input  logic [XLEN-1:0]  rf_val_b_i,
  input  logic [RID_W-1:0] e_dst_e_i,
  input  logic [XLEN-1:0]  e_val_e_i,
  input  logic [RID_W-1:0] m_dst_m_i,
  input  logic [XLEN-1:0]  m_val_m_i,
  input  logic [RID_W-1:0] m_dst_e_i,
  input  logic [XLEN-1:0]  m_val_e_i,
  input  logic [RID_W-1:0] w_dst_m_i,
  input  logic [XLEN-1:0]  w_val_m_i,
  input  logic [RID_W-1:0] w_dst_e_i,
  input  logic [XLEN-1:0]  w_val_e_i,
  output logic [XLEN-1:0]  val_a_o,
  output logic [XLEN-1:0]  val_b_o,
  output logic [RID_W-1:0] dst_e_o
);
  logic [RID_W-1:0] pend_id  [NSRC];
  logic [XLEN-1:0]  pend_val [NSRC];
  logic             is_ctl_xfer;

  // priority order: newest pending result first
  assign pend_id[0] = e_dst_e_i;  assign pend_val[0] = e_val_e_i;
  assign pend_id[1] = m_dst_m_i;  assign pend_val[1] = m_val_m_i;
  assign pend_id[2] = m_dst_e_i;  assign pend_val[2] = m_val_e_i;
  assign pend_id[3] = w_dst_m_i;  assign pend_val[3] = w_val_m_i;
  assign pend_id[4] = w_dst_e_i;  assign pend_val[4] = w_val_e_i;

  assign is_ctl_xfer = (d_icode_i == OP_CALL) || (d_icode_i == OP_JMP);

  opfwd_operand_mux #(.W(XLEN), .RW(RID_W), .N(NSRC), .USE_VALP(1'b1)) i_mux_a (
    .take_valp_i (is_ctl_xfer),
    .valp_i      (d_valp_i),
    .src_id_i    (d_src_a_i),
    .rf_val_i    (rf_val_a_i),
    .pend_id_i   (pend_id),
    .pend_val_i  (pend_val),
    .val_o       (val_a_o)
  );

  opfwd_operand_mux #(.W(XLEN), .RW(RID_W), .N(NSRC), .USE_VALP(1'b0)) i_mux_b (
    .take_valp_i (1'b0),
    .valp_i      ('0),
    .src_id_i    (d_src_b_i),
    .rf_val_i    (rf_val_b_i),
    .pend_id_i   (pend_id),
    .pend_val_i  (pend_val),
    .val_o       (val_b_o)
  );

  opfwd_dst_sel #(.RW(RID_W)) i_dst_sel (
    .icode_i (d_icode_i),
    .rb_i    (d_rb_i),
    .dst_e_o (dst_e_o)
  );
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk
  import opfwd_pkg::*;
(
  input logic [3:0]       d_icode_i,
  input logic [RID_W-1:0] d_rb_i,
  input logic [RID_W-1:0] d_src_a_i,
  input logic [RID_W-1:0] d_src_b_i,
  input logic [XLEN-1:0]  d_valp_i,
  input logic [XLEN-1:0]  rf_val_a_i,
  input logic [XLEN-1:0]  rf_val_b_i,
  input logic [RID_W-1:0] e_dst_e_i,
  input logic [XLEN-1:0]  e_val_e_i,
  input logic [RID_W-1:0] m_dst_m_i,
  input logic [XLEN-1:0]  m_val_m_i,
  input logic [RID_W-1:0] m_dst_e_i,
  input logic [XLEN-1:0]  m_val_e_i,
  input logic [RID_W-1:0] w_dst_m_i,
  input logic [XLEN-1:0]  w_val_m_i,
  input logic [RID_W-1:0] w_dst_e_i,
  input logic [XLEN-1:0]  w_val_e_i,
  input logic [XLEN-1:0]  val_a_o,
  input logic [XLEN-1:0]  val_b_o,
  input logic [RID_W-1:0] dst_e_o
);
  logic ctl;
  assign ctl = (d_icode_i == OP_CALL) || (d_icode_i == OP_JMP);

  always_comb begin
    // R1
    valp_pass_chk: assert (!ctl || val_a_o == d_valp_i)
      else $error("valA not valP for control transfer");
    // R2
    exec_first_chk: assert (!(d_src_b_i != RID_NONE && d_src_b_i == e_dst_e_i) || val_b_o == e_val_e_i)
      else $error("valB missed execute forward");
    // R8
    none_src_chk: assert (ctl || d_src_a_i != RID_NONE || val_a_o == rf_val_a_i)
      else $error("RNONE source forwarded");
    // R10
    dst_legal_chk: assert (dst_e_o == RID_NONE || dst_e_o == RID_SP || dst_e_o == d_rb_i)
      else $error("dstE outside allowed set");
  end

  logic unused_chk;
  assign unused_chk = ^{m_dst_m_i, m_val_m_i, m_dst_e_i, m_val_e_i,
                        w_dst_m_i, w_val_m_i, w_dst_e_i, w_val_e_i, rf_val_b_i};
endmodule

bind opfwd_unit opfwd_unit_chk i_chk (.*);

// File: tb/test_opfwd_unit.sv
module test_opfwd_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [3:0]  d_icode, d_rb, src_a, src_b;
  logic [3:0]  e_de, m_dm, m_de, w_dm, w_de;
  logic [63:0] valp, rfa, rfb, e_ve, m_vm, m_ve, w_vm, w_ve;
  logic [63:0] val_a, val_b;
  logic [3:0]  dst_e;

  int n_chk = 0;
  int n_bad = 0;

  opfwd_unit i_opfwd_unit (
    .d_icode_i(d_icode), .d_rb_i(d_rb), .d_src_a_i(src_a), .d_src_b_i(src_b),
    .d_valp_i(valp), .rf_val_a_i(rfa), .rf_val_b_i(rfb),
    .e_dst_e_i(e_de), .e_val_e_i(e_ve), .m_dst_m_i(m_dm), .m_val_m_i(m_vm),
    .m_dst_e_i(m_de), .m_val_e_i(m_ve), .w_dst_m_i(w_dm), .w_val_m_i(w_vm),
    .w_dst_e_i(w_de), .w_val_e_i(w_ve),
    .val_a_o(val_a), .val_b_o(val_b), .dst_e_o(dst_e)
  );

  // expected-source codes
  localparam logic [2:0] S_E = 0, S_MM = 1, S_ME = 2, S_WM = 3, S_WE = 4, S_RF = 5, S_VP = 6;

  typedef struct packed {
    logic [3:0] icode, rb, sa, sb, ed, mmd, med, wmd, wed;
    logic [2:0] xa, xb;
    logic [3:0] xdst;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{4'h6,4'h3,4'h1,4'h3, 4'hF,4'hF,4'hF,4'hF,4'hF, S_RF,S_RF,4'h3}, // R7 R10
    '{4'h6,4'h3,4'h1,4'h3, 4'h1,4'h1,4'h1,4'h1,4'h1, S_E ,S_RF,4'h3}, // R2
    '{4'h6,4'h3,4'h1,4'h1, 4'h2,4'h1,4'h1,4'h1,4'h1, S_MM,S_MM,4'h3}, // R3
    '{4'h6,4'h3,4'h1,4'h1, 4'h2,4'h2,4'h1,4'h1,4'h1, S_ME,S_ME,4'h3}, // R4
    '{4'h6,4'h3,4'h1,4'h1, 4'h2,4'h2,4'h2,4'h1,4'h1, S_WM,S_WM,4'h3}, // R5
    '{4'h6,4'h3,4'h1,4'h1, 4'h2,4'h2,4'h2,4'h2,4'h1, S_WE,S_WE,4'h3}, // R6
    '{4'h8,4'hF,4'h4,4'h4, 4'h4,4'h4,4'h4,4'h4,4'h4, S_VP,S_E ,4'h4}, // R1 R9
    '{4'h7,4'hF,4'h2,4'hF, 4'hF,4'hF,4'hF,4'hF,4'h2, S_VP,S_RF,4'hF}, // R1
    '{4'h1,4'hF,4'hF,4'hF, 4'hF,4'hF,4'hF,4'hF,4'hF, S_RF,S_RF,4'hF}, // R8
    '{4'hA,4'hF,4'hF,4'h5, 4'hF,4'h5,4'h5,4'h5,4'h5, S_RF,S_MM,4'h4}, // R9
    '{4'hB,4'hF,4'hF,4'h5, 4'hF,4'hF,4'h5,4'h5,4'h5, S_RF,S_ME,4'h4}, // R9
    '{4'h9,4'hF,4'hF,4'h5, 4'hF,4'hF,4'hF,4'h5,4'h5, S_RF,S_WM,4'h4}, // R9
    '{4'h2,4'h7,4'hF,4'h5, 4'hF,4'hF,4'hF,4'hF,4'h5, S_RF,S_WE,4'h7}, // R6 R10
    '{4'h3,4'h9,4'h0,4'hE, 4'h0,4'hF,4'hF,4'hF,4'hE, S_E ,S_WE,4'h9}, // R2 R10
    '{4'h5,4'h2,4'hF,4'hF, 4'h3,4'h3,4'h3,4'h3,4'h3, S_RF,S_RF,4'hF}, // R8 R10
    '{4'h4,4'h2,4'h3,4'h6, 4'h2,4'h4,4'h5,4'h7,4'h8, S_RF,S_RF,4'hF}, // R7 R10
    '{4'h0,4'h2,4'hE,4'hE, 4'hD,4'hC,4'hB,4'hA,4'h9, S_RF,S_RF,4'hF}  // R7 R10
  };

  function automatic logic [63:0] pick(input logic [2:0] s, input logic [63:0] rf);
    case (s)
      S_E:  return e_ve;
      S_MM: return m_vm;
      S_ME: return m_ve;
      S_WM: return w_vm;
      S_WE: return w_ve;
      S_VP: return valp;
      default: return rf;
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    d_icode = v.icode; d_rb = v.rb; src_a = v.sa; src_b = v.sb;
    e_de = v.ed; m_dm = v.mmd; m_de = v.med; w_dm = v.wmd; w_de = v.wed;
    #2;
  endtask

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    valp = 64'h0000_0000_0040_1000; rfa = 64'hAAAA_0000_0000_000A;
    rfb  = 64'hBBBB_0000_0000_000B; e_ve = 64'h1111_1111_1111_1111;
    m_vm = 64'h2222_2222_2222_2222; m_ve = 64'h3333_3333_3333_3333;
    w_vm = 64'h4444_4444_4444_4444; w_ve = 64'h5555_5555_5555_5555;

    // idle state: all IDs none, no forwarding, dstE none (R8, R10)
    apply('{4'h1,4'hF,4'hF,4'hF, 4'hF,4'hF,4'hF,4'hF,4'hF, S_RF,S_RF,4'hF});
    check64("R8 idle valA", val_a, rfa);
    check64("R8 idle valB", val_b, rfb);
    check4 ("R10 idle dstE", dst_e, 4'hF);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      check64($sformatf("vec%0d valA", i), val_a, pick(VT[i].xa, rfa));
      check64($sformatf("vec%0d valB", i), val_b, pick(VT[i].xb, rfb));
      check4 ($sformatf("vec%0d dstE", i), dst_e, VT[i].xdst);
    end

    // R2: data changes propagate while IDs stay put
    apply('{4'h6,4'h3,4'h1,4'h1, 4'h1,4'h1,4'h1,4'h1,4'h1, S_E,S_E,4'h3});
    e_ve = 64'hDEAD_BEEF_0000_0001; #2;
    check64("R2 live e_val valA", val_a, 64'hDEAD_BEEF_0000_0001);
    check64("R2 live e_val valB", val_b, 64'hDEAD_BEEF_0000_0001);

    // R1: every opcode other than 7/8 forwards valA normally
    for (int op = 0; op < 16; op++) begin
      apply('{op[3:0],4'h3,4'h6,4'hF, 4'hF,4'hF,4'hF,4'hF,4'h6, S_WE,S_RF,4'hF});
      check64($sformatf("R1 op%0d valA", op), val_a, (op == 7 || op == 8) ? valp : w_ve);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule